// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer whose write side and read side run on independent clocks. Words enter on the write clock under a pair of write enables and leave on the read clock under a pair of read enables. A registered output drives a shared bus only while the output enable is low. The read and write pointers cross between the clock domains as Gray codes through multi-stage synchronisers. Each side works out its own flags from its own pointer and the synchronised pointer from the other side.

Five active-low status flags are produced. Empty and almost-empty belong to the read clock. Full, half-full and almost-full belong to the write clock. The two almost thresholds come from two 16-bit offset registers. Holding the second write-enable pin low turns the write port into a loader that fills these registers one byte per write-clock edge, in a fixed rotating order. While that pin is low, read requests return the same bytes in the same order instead of FIFO data.

Top module: `dcfifo_flagged`

## Requirements
- R1: A word on `din` is stored on a rising `wr_clk` edge when `wr_en1_n` is 0, `wr_en2_ld` is 1 and `full_n` is 1. Words come out in the order they were stored.
- R2: A word is read on a rising `rd_clk` edge when `rd_en1_n` and `rd_en2_n` are both 0, `empty_n` is 1 and the load pin is high (synchronised into the read domain). The word appears on the output register after that same edge.
- R3: While `oe_n` is 1, `dout` is released to high impedance. While `oe_n` is 0, `dout` drives the output register.
- R4: `rst_n` low empties the buffer and clears the output register to 0. The flags then read `empty_n`=0, `aempty_n`=0, `full_n`=1, `half_n`=1, `afull_n`=1. Both offsets return to `DEF_OFS` (7), and the load and readback positions return to the almost-empty low byte.
- R5: `full_n` is 0 exactly when `DEPTH` words are unread. A write attempted while it is 0 is dropped.
- R6: `empty_n` is 0 exactly when no word is unread. A read attempted while it is 0 leaves the read pointer and `dout` unchanged.
- R7: `half_n` is 0 when more than `DEPTH/2` words are unread.
- R8: `afull_n` is 0 when the unread count is at least `DEPTH` minus the almost-full offset.
- R9: `aempty_n` is 0 when the unread count is at most the almost-empty offset. It passes through one extra read-clock register stage.
- R10: With `wr_en1_n`=0 and `wr_en2_ld`=0, each `wr_clk` edge writes `din[7:0]` into the next byte of the rotation. The rotation is almost-empty low, almost-empty high, almost-full low, almost-full high, and then it wraps. No data word is stored.
- R11: With `wr_en2_ld` held at 0, each read request returns the next offset byte in the same rotation as {0, byte} on `dout`. The FIFO contents are not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Master reset, active low, asynchronous to both domains |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | High: data write; low: offset load / readback mode |
| din | input | DW | Write data; low byte feeds offset loads |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output drive enable, active low |
| dout | output | DW | Tri-stated read data |
| empty_n | output | 1 | Low when nothing is unread (read domain) |
| full_n | output | 1 | Low when every location is unread (write domain) |
| half_n | output | 1 | Low when more than half the locations are unread |
| aempty_n | output | 1 | Low when unread count is at or below the almost-empty offset |
| afull_n | output | 1 | Low when unread count is at or above depth minus almost-full offset |

## Verification
The buffer is first filled one word at a time and then drained one word at a time. The flags are checked at every fill level, so each threshold is caught on the exact word where it moves, including one past full and one past empty. A free-running phase then writes faster than it reads, on unrelated clocks, and compares every accepted word with a queue. This separates an ordering or pointer-crossing fault from a fault in a static threshold. The offset path is driven with multi-byte values and an odd number of loads, so a wrong byte order or a missing wrap shows up in the readback.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   // Position in the offset byte rotation; the order is part of the behaviour.
   typedef enum logic [1:0] {
      OFS_AE_LO = 2'd0,
      OFS_AE_HI = 2'd1,
      OFS_AF_LO = 2'd2,
      OFS_AF_HI = 2'd3
   } ofs_step_e;

   localparam int OFS_W = 16;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
   parameter int DW = 9,
   parameter int AW = 6
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int ENTRIES = 1 << AW;

   logic [DW-1:0] mem [ENTRIES];

   always_ff @(posedge wr_clk)
      if (we) mem[waddr] <= wdata;

   assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
   import dcf_pkg::*;
#(
   parameter int AW      = 6,
   parameter int DEF_OFS = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en1_n,
   input  logic             en2_ld,
   input  logic [7:0]       ld_byte,
   input  logic [AW:0]      rgray_s,
   output logic             we,
   output logic [AW-1:0]    waddr,
   output logic [AW:0]      wgray,
   output logic             full_n,
   output logic             half_n,
   output logic             afull_n,
   output logic [OFS_W-1:0] ofs_ae,
   output logic [OFS_W-1:0] ofs_af
);
   localparam int          PW     = AW + 1;
   localparam logic [PW:0] DEPTH_X = (PW+1)'(1) << AW;
   localparam logic [PW:0] HALF_X  = DEPTH_X >> 1;

   logic [PW-1:0] wbin_q, wbin_nx, rbin_s, cnt_nx;
   logic          wr_go, ld_go;
   ofs_step_e     ld_step;

   assign wr_go   = !en1_n && en2_ld && full_n;
   assign ld_go   = !en1_n && !en2_ld;
   assign wbin_nx = wbin_q + PW'(wr_go);

   always_comb begin
      rbin_s[PW-1] = rgray_s[PW-1];
      for (int i = PW - 2; i >= 0; i--)
         rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
   end

   assign cnt_nx = wbin_nx - rbin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin_q  <= '0;
         wgray   <= '0;
         full_n  <= 1'b1;
         half_n  <= 1'b1;
         afull_n <= 1'b1;
      end else begin
         wbin_q  <= wbin_nx;
         wgray   <= wbin_nx ^ (wbin_nx >> 1);
         full_n  <= !({1'b0, cnt_nx} == DEPTH_X);
         half_n  <= !({1'b0, cnt_nx} > HALF_X);
         afull_n <= !((17'(cnt_nx) + 17'(ofs_af)) >= 17'(DEPTH_X));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_ae  <= OFS_W'(DEF_OFS);
         ofs_af  <= OFS_W'(DEF_OFS);
         ld_step <= OFS_AE_LO;
      end else if (ld_go) begin
         case (ld_step)
            OFS_AE_LO: ofs_ae[7:0]  <= ld_byte;
            OFS_AE_HI: ofs_ae[15:8] <= ld_byte;
            OFS_AF_LO: ofs_af[7:0]  <= ld_byte;
            OFS_AF_HI: ofs_af[15:8] <= ld_byte;
         endcase
         ld_step <= ofs_step_e'(ld_step + 2'd1);
      end
   end

   assign we    = wr_go;
   assign waddr = wbin_q[AW-1:0];
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
   import dcf_pkg::*;
#(
   parameter int DW        = 9,
   parameter int AW        = 6,
   parameter bit AE_RETIME = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en1_n,
   input  logic             en2_n,
   input  logic             ldm_s,
   input  logic [AW:0]      wgray_s,
   input  logic [OFS_W-1:0] ofs_ae,
   input  logic [OFS_W-1:0] ofs_af,
   input  logic [DW-1:0]    rdata,
   output logic [AW-1:0]    raddr,
   output logic [AW:0]      rgray,
   output logic             empty_n,
   output logic             aempty_n,
   output logic [DW-1:0]    q
);
   localparam int PW = AW + 1;

   logic [PW-1:0] rbin_q, rbin_nx, wbin_s, cnt_nx;
   logic          rd_req, rd_go, rb_go, ae_calc_n;
   logic [7:0]    rb_byte;
   ofs_step_e     rb_step;

   assign rd_req  = !en1_n && !en2_n;
   assign rd_go   = rd_req && !ldm_s && empty_n;
   assign rb_go   = rd_req && ldm_s;
   assign rbin_nx = rbin_q + PW'(rd_go);

   always_comb begin
      wbin_s[PW-1] = wgray_s[PW-1];
      for (int i = PW - 2; i >= 0; i--)
         wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
   end

   assign cnt_nx    = wbin_s - rbin_nx;
   assign ae_calc_n = !(17'(cnt_nx) <= 17'(ofs_ae));

   always_comb begin
      case (rb_step)
         OFS_AE_LO: rb_byte = ofs_ae[7:0];
         OFS_AE_HI: rb_byte = ofs_ae[15:8];
         OFS_AF_LO: rb_byte = ofs_af[7:0];
         OFS_AF_HI: rb_byte = ofs_af[15:8];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin_q  <= '0;
         rgray   <= '0;
         empty_n <= 1'b0;
         q       <= '0;
         rb_step <= OFS_AE_LO;
      end else begin
         rbin_q  <= rbin_nx;
         rgray   <= rbin_nx ^ (rbin_nx >> 1);
         empty_n <= !(cnt_nx == '0);
         if (rd_go) begin
            q <= rdata;
         end else if (rb_go) begin
            q       <= DW'(rb_byte);
            rb_step <= ofs_step_e'(rb_step + 2'd1);
         end
      end
   end

   if (AE_RETIME) begin : g_ae_retime
      logic ae_pre_n;
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) begin
            ae_pre_n <= 1'b0;
            aempty_n <= 1'b0;
         end else begin
            ae_pre_n <= ae_calc_n;
            aempty_n <= ae_pre_n;
         end
   end else begin : g_ae_direct
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) aempty_n <= 1'b0;
         else        aempty_n <= ae_calc_n;
   end

   assign raddr = rbin_q[AW-1:0];
endmodule

// File: rtl/dcfifo_flagged.sv
module dcfifo_flagged
   import dcf_pkg::*;
#(
   parameter int DW          = 9,
   parameter int DEPTH       = 64,
   parameter int SYNC_STAGES = 2,
   parameter int DEF_OFS     = 7,
   parameter bit AE_RETIME   = 1'b1
) (
   input  logic          wr_clk,
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          wr_en1_n,
   input  logic          wr_en2_ld,
   input  logic [DW-1:0] din,
   input  logic          rd_en1_n,
   input  logic          rd_en2_n,
   input  logic          oe_n,
   output wire  [DW-1:0] dout,
   output logic          empty_n,
   output logic          full_n,
   output logic          half_n,
   output logic          aempty_n,
   output logic          afull_n
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 4 || DEPTH > 32768) begin : g_bad_depth
      $error("dcfifo_flagged: DEPTH must be a power of two in 4..32768");
   end
   if (DW < 9) begin : g_bad_width
      $error("dcfifo_flagged: DW must be at least 9");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dcfifo_flagged: SYNC_STAGES must be at least 2");
   end
   if (DEF_OFS < 0 || DEF_OFS >= DEPTH) begin : g_bad_ofs
      $error("dcfifo_flagged: DEF_OFS must lie in 0..DEPTH-1");
   end

   logic [PW-1:0]    wgray, rgray, wgray_s, rgray_s;
   logic             we, ldm_s;
   logic [AW-1:0]    waddr, raddr;
   logic [DW-1:0]    rdata, q;
   logic [OFS_W-1:0] ofs_ae, ofs_af;

   dcf_ram #(.DW(DW), .AW(AW)) u_ram (
      .wr_clk (wr_clk),
      .we     (we),
      .waddr  (waddr),
      .wdata  (din),
      .raddr  (raddr),
      .rdata  (rdata)
   );

   dcf_wr_ctl #(.AW(AW), .DEF_OFS(DEF_OFS)) u_wr (
      .clk     (wr_clk),
      .rst_n   (rst_n),
      .en1_n   (wr_en1_n),
      .en2_ld  (wr_en2_ld),
      .ld_byte (din[7:0]),
      .rgray_s (rgray_s),
      .we      (we),
      .waddr   (waddr),
      .wgray   (wgray),
      .full_n  (full_n),
      .half_n  (half_n),
      .afull_n (afull_n),
      .ofs_ae  (ofs_ae),
      .ofs_af  (ofs_af)
   );

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk (rd_clk), .rst_n (rst_n), .d (wgray), .q (wgray_s)
   );

   dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk (wr_clk), .rst_n (rst_n), .d (rgray), .q (rgray_s)
   );

   dcf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ldm (
      .clk (rd_clk), .rst_n (rst_n), .d (!wr_en2_ld), .q (ldm_s)
   );

   dcf_rd_ctl #(.DW(DW), .AW(AW), .AE_RETIME(AE_RETIME)) u_rd (
      .clk      (rd_clk),
      .rst_n    (rst_n),
      .en1_n    (rd_en1_n),
      .en2_n    (rd_en2_n),
      .ldm_s    (ldm_s),
      .wgray_s  (wgray_s),
      .ofs_ae   (ofs_ae),
      .ofs_af   (ofs_af),
      .rdata    (rdata),
      .raddr    (raddr),
      .rgray    (rgray),
      .empty_n  (empty_n),
      .aempty_n (aempty_n),
      .q        (q)
   );

   assign dout = oe_n ? {DW{1'bz}} : q;
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
   parameter int AW = 6
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          rst_n,
   input logic          empty_n,
   input logic          full_n,
   input logic          half_n,
   input logic          afull_n,
   input logic          aempty_n,
   input logic [AW-1:0] waddr,
   input logic [AW-1:0] raddr
);
   // R1
   wr_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (waddr != $past(waddr)) |-> (waddr == AW'($past(waddr) + 1'b1)));

   // R2
   rd_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (raddr != $past(raddr)) |-> (raddr == AW'($past(raddr) + 1'b1)));

   // R4
   wr_reset_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $rose(rst_n) |-> (full_n && half_n && afull_n));

   // R4
   rd_reset_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!empty_n && !aempty_n));

   // R5
   no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |=> $stable(waddr));

   // R6
   no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |=> $stable(raddr));

   // R7
   full_half_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |-> !half_n);

   // R8
   full_afull_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |-> !afull_n);

   // R9
   empty_aempty_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!empty_n && $past(!empty_n)) |-> !aempty_n);
endmodule

bind dcfifo_flagged dcf_chk #(.AW(AW)) u_chk (
   .wr_clk   (wr_clk),
   .rd_clk   (rd_clk),
   .rst_n    (rst_n),
   .empty_n  (empty_n),
   .full_n   (full_n),
   .half_n   (half_n),
   .afull_n  (afull_n),
   .aempty_n (aempty_n),
   .waddr    (waddr),
   .raddr    (raddr)
);

// File: tb/tb_dcfifo_flagged.sv
`timescale 1ns/1ps
module tb_dcfifo_flagged;
   localparam int DW      = 9;
   localparam int DEPTH   = 64;
   localparam int DEF_OFS = 7;

   logic          wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
   logic          wr_en1_n = 1'b1, wr_en2_ld = 1'b1;
   logic          rd_en1_n = 1'b1, rd_en2_n = 1'b1, oe_n = 1'b0;
   logic [DW-1:0] din = '0;
   wire  [DW-1:0] dout;
   logic          empty_n, full_n, half_n, aempty_n, afull_n;

   for (genvar gi = 0; gi < DW; gi++) begin : g_pu
      pullup (dout[gi]);
   end

   dcfifo_flagged #(.DW(DW), .DEPTH(DEPTH), .DEF_OFS(DEF_OFS)) dut (
      .wr_clk, .rd_clk, .rst_n, .wr_en1_n, .wr_en2_ld, .din,
      .rd_en1_n, .rd_en2_n, .oe_n, .dout,
      .empty_n, .full_n, .half_n, .aempty_n, .afull_n
   );

   always #4   wr_clk = ~wr_clk;   // 125 MHz
   always #5.5 rd_clk = ~rd_clk;   // unrelated read clock

   int            checks = 0, errors = 0;
   logic [DW-1:0] model_q [$];
   int            mae = DEF_OFS, maf = DEF_OFS;
   logic [DW-1:0] last_rd = '0;

   function automatic logic [DW-1:0] pat(int i, int k);
      return DW'((i * k + 5) & 9'h1ff);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (12) @(posedge rd_clk);
      @(negedge rd_clk);
   endtask

   task automatic check_flags();
      int n = model_q.size();
      chk("R6 empty_n",  32'(empty_n),  32'(n != 0));
      chk("R5 full_n",   32'(full_n),   32'(n != DEPTH));
      chk("R7 half_n",   32'(half_n),   32'(!(n > DEPTH / 2)));
      chk("R8 afull_n",  32'(afull_n),  32'(!(n >= DEPTH - maf)));
      chk("R9 aempty_n", 32'(aempty_n), 32'(!(n <= mae)));
   endtask

   task automatic wr_word(input logic [DW-1:0] d, output bit acc);
      @(negedge wr_clk);
      wr_en1_n = 1'b0; wr_en2_ld = 1'b1; din = d;
      acc = full_n;
      @(posedge wr_clk);
      #1 wr_en1_n = 1'b1;
      if (acc) model_q.push_back(d);
   endtask

   task automatic rd_word(output bit acc);
      logic [DW-1:0] exp;
      @(negedge rd_clk);
      rd_en1_n = 1'b0; rd_en2_n = 1'b0;
      acc = empty_n;
      @(posedge rd_clk);
      #1 rd_en1_n = 1'b1; rd_en2_n = 1'b1;
      if (acc) begin
         exp = model_q.pop_front();
         chk("R1 R2 read data order", 32'(dout), 32'(exp));
         last_rd = exp;
      end else begin
         chk("R6 read while empty holds dout", 32'(dout), 32'(last_rd));
      end
   endtask

   task automatic ld_byte(input logic [7:0] b);
      @(negedge wr_clk);
      wr_en1_n = 1'b0; wr_en2_ld = 1'b0; din = {1'b0, b};
      @(posedge wr_clk);
      #1 wr_en1_n = 1'b1;
   endtask

   task automatic rb_read(input logic [7:0] b, input string tag);
      @(negedge rd_clk);
      rd_en1_n = 1'b0; rd_en2_n = 1'b0;
      @(posedge rd_clk);
      #1 rd_en1_n = 1'b1; rd_en2_n = 1'b1;
      chk(tag, 32'(dout), 32'({1'b0, b}));
      last_rd = {1'b0, b};
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit acc;
      #30 rst_n = 1'b1;
      settle();
      // R4 state after reset
      chk("R4 empty_n", 32'(empty_n), 0);
      chk("R4 dout", 32'(dout), 0);
      check_flags();
      // R3 output release and drive
      oe_n = 1'b1; #3;
      chk("R3 released bus", 32'(dout), 32'h1ff);
      oe_n = 1'b0; #3;
      chk("R3 driven bus", 32'(dout), 0);

      // R4 R11 default offsets read back in rotation
      wr_en2_ld = 1'b0;
      settle();
      rb_read(8'd7, "R4 R11 default ae lo");
      rb_read(8'd0, "R4 R11 default ae hi");
      rb_read(8'd7, "R4 R11 default af lo");
      rb_read(8'd0, "R4 R11 default af hi");

      // R10 load four bytes, then read them back
      ld_byte(8'h12); ld_byte(8'h01); ld_byte(8'h34); ld_byte(8'h02);
      mae = 16'h0112; maf = 16'h0234;
      settle();
      rb_read(8'h12, "R10 R11 ae lo");
      rb_read(8'h01, "R10 R11 ae hi");
      rb_read(8'h34, "R10 R11 af lo");
      rb_read(8'h02, "R10 R11 af hi");
      chk("R10 load stores no data", 32'(empty_n), 0);
      check_flags();

      // R10 wrap: fifth load lands on almost-empty low byte again
      ld_byte(8'd3); ld_byte(8'd0); ld_byte(8'd9); ld_byte(8'd0); ld_byte(8'd5);
      mae = 5; maf = 9;
      settle();
      rb_read(8'd5, "R10 R11 wrap ae lo");
      rb_read(8'd0, "R11 ae hi");
      rb_read(8'd9, "R11 af lo");
      rb_read(8'd0, "R11 af hi");
      wr_en2_ld = 1'b1;
      settle();
      check_flags();

      // fill one word at a time, every level checked
      for (int i = 0; i < DEPTH; i++) begin
         wr_word(pat(i, 37), acc);
         chk("R1 write accepted below full", 32'(acc), 1);
         settle();
         check_flags();
      end
      // R5 write while full is dropped
      wr_word(9'h1ab, acc);
      chk("R5 write refused when full", 32'(acc), 0);
      settle();
      check_flags();

      // drain one word at a time
      for (int i = 0; i < DEPTH; i++) begin
         rd_word(acc);
         chk("R2 read accepted while not empty", 32'(acc), 1);
         settle();
         check_flags();
      end
      // R6 read when empty holds output
      rd_word(acc);
      chk("R6 read refused when empty", 32'(acc), 0);
      settle();
      check_flags();

      // R3 again with data on the register
      oe_n = 1'b1; #3;
      chk("R3 released bus", 32'(dout), 32'h1ff);
      oe_n = 1'b0; #3;
      chk("R3 driven bus", 32'(dout), 32'(last_rd));

      // free-running phase: faster writer, slower reader
      fork
         begin
            int sent = 0;
            bit a;
            while (sent < 300) begin
               wr_word(pat(sent, 101), a);
               if (a) sent++;
            end
         end
         begin
            int got = 0;
            bit a;
            while (got < 300) begin
               rd_word(a);
               if (a) got++;
            end
         end
      join
      settle();
      check_flags();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule